// File: doc/BRIEF.md
# Register Write Guard

This block decides, for every bus write aimed at a small peripheral register file, whether the write may land. It keeps a four-bit lock register. Each lock bit guards one target: the lock register itself, the status register, the control register or the compensation register. A bit at 1 leaves its target writable. Software can only clear a lock bit. Once cleared, the bit stays cleared until power-on reset or a software reset.

The block also owns three control bits:
- an update-mode override, which keeps the counter-enable write open on a locked status register while time is invalid, the counter has overflowed, or the counter is stopped;
- a supervisor-access enable, which opens writes to non-supervisor code;
- a software-reset bit, which returns the block's state to reset values and sends a one-cycle reset pulse to the other registers.

The per-register write-allow outputs and the bus error are combinational. They are valid in the same cycle as the write strobe, so the owner of each target register uses them directly as its write enable.

Top module: `reg_guard`

## Requirements
- R1: After power-on reset the lock state reads 4'b1111, the update-mode, supervisor-access and software-reset bits read 0, and sw_reset and bus_err are low.
- R2: Lock bits are bit 0 lock-register lock, bit 1 status lock, bit 2 control lock and bit 3 compensation lock. An accepted write to the lock register (address 6) makes the new lock state the old state ANDed with wr_data[3:0], so no bit can be set by software.
- R3: With lock bit 0 cleared, a write to the lock register is ignored: wr_ok[6] stays low and the lock state does not change.
- R4: With lock bit 2 cleared, a write to the control register (address 4) is ignored: wr_ok[4] stays low, the control bits do not change and no software reset starts.
- R5: wr_ok[3] (compensation register, address 3) follows lock bit 3 for an accepted write.
- R6: With lock bit 1 cleared and update mode off, a write to the status register (address 5) is refused (wr_ok[5] low).
- R7: With lock bit 1 cleared and update mode on, a write to the status register is allowed exactly when time_invalid is high, time_overflow is high or cnt_enabled is low.
- R8: While supervisor access (control bit 1) is 0, a write with priv low raises bus_err in the same cycle, asserts no wr_ok bit and changes no state. Supervisor writes, or any write once supervisor access is 1, raise no bus error.
- R9: A write ignored because of a lock raises no bus error.
- R10: An accepted control write with wr_data[0]=1 sets the software-reset bit. On the same clock edge it returns the lock state to 4'b1111 and clears update mode (bit 2) and supervisor access (bit 1). sw_reset is high for the one following cycle.
- R11: The software-reset bit clears only on power-on reset or on an accepted control write with wr_data[0]=0. Writes to other registers leave it set.
- R12: Address map: 0 seconds, 1 prescaler, 2 alarm, 3 compensation, 4 control, 5 status, 6 lock, 7 interrupt enable. wr_ok has at most one bit set, only while wr_en is high, and registers 0, 1, 2 and 7 are always writable for an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 3 | Register index of the write |
| wr_data | input | 4 | Write data |
| priv | input | 1 | Write issued in supervisor mode |
| time_invalid | input | 1 | Time-invalid flag from the status register |
| time_overflow | input | 1 | Counter-overflow flag from the status register |
| cnt_enabled | input | 1 | Counter-enable bit from the status register |
| wr_ok | output | 8 | Per-register write allow, one bit per address |
| bus_err | output | 1 | Write rejected for lack of supervisor rights |
| sw_reset | output | 1 | One-cycle software reset pulse to the other registers |
| lock_state | output | 4 | Current lock bits |
| upd_mode | output | 1 | Update-mode control bit |
| sup_en | output | 1 | Supervisor-access control bit |
| swr_flag | output | 1 | Software-reset control bit |

## Verification
The assertions check on every cycle that:
- a bus error never comes with a write allow and never alters state;
- lock bits rise only through a software reset;
- a lock-register write only clears bits;
- wr_ok stays one-hot and tied to the strobe;
- a software reset is always followed by the reset pulse and the reset values.

Only the bench's scenarios show the rest: which register each lock bit really protects, the update-mode override under each of its three conditions, the software-reset bit persisting across unrelated writes, and the locks coming back only after a reset.

// File: rtl/reg_guard_pkg.sv
package reg_guard_pkg;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int LOCK_W   = 4;
  localparam int CTRL_W   = 3;
  localparam int DATA_W   = (LOCK_W > CTRL_W) ? LOCK_W : CTRL_W;

  // register indices
  localparam int IDX_SECONDS = 0;
  localparam int IDX_PRESCAL = 1;
  localparam int IDX_ALARM   = 2;
  localparam int IDX_COMP    = 3;
  localparam int IDX_CTRL    = 4;
  localparam int IDX_STATUS  = 5;
  localparam int IDX_LOCK    = 6;
  localparam int IDX_IRQEN   = 7;

  // lock bit positions
  localparam int LK_SELF = 0;
  localparam int LK_STAT = 1;
  localparam int LK_CTRL = 2;
  localparam int LK_COMP = 3;

  // control bit positions
  localparam int CB_SWR = 0;
  localparam int CB_SUP = 1;
  localparam int CB_UM  = 2;

  typedef struct packed {
    logic um;
    logic sup;
    logic swr;
  } ctrl_t;
endpackage

// File: rtl/reg_guard_access.sv
module reg_guard_access (
  input  logic wr_en_i,
  input  logic priv_i,
  input  logic sup_en_i,
  output logic accept_o,
  output logic bus_err_o
);
  logic rights_ok;

  always_comb begin
    rights_ok = priv_i | sup_en_i;
    accept_o  = wr_en_i & rights_ok;
    bus_err_o = wr_en_i & ~rights_ok;
  end
endmodule

// File: rtl/reg_guard_gate.sv
module reg_guard_gate
  import reg_guard_pkg::*;
(
  input  logic                accept_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [LOCK_W-1:0]   lock_i,
  input  logic                um_i,
  input  logic                invalid_i,
  input  logic                overflow_i,
  input  logic                cnt_en_i,
  output logic [NUM_REGS-1:0] wr_ok_o
);
  logic tce_override;

  always_comb begin
    tce_override = um_i & (invalid_i | overflow_i | ~cnt_en_i);
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = accept_i && (addr_i == ADDR_W'(i));
    if (i == IDX_LOCK) begin : g_lock
      assign wr_ok_o[i] = hit & lock_i[LK_SELF];
    end else if (i == IDX_STATUS) begin : g_stat
      assign wr_ok_o[i] = hit & (lock_i[LK_STAT] | tce_override);
    end else if (i == IDX_CTRL) begin : g_ctrl
      assign wr_ok_o[i] = hit & lock_i[LK_CTRL];
    end else if (i == IDX_COMP) begin : g_comp
      assign wr_ok_o[i] = hit & lock_i[LK_COMP];
    end else begin : g_open
      assign wr_ok_o[i] = hit;
    end
  end
endmodule

// File: rtl/reg_guard_lock.sv
module reg_guard_lock
  import reg_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [LOCK_W-1:0] wdata_i,
  input  logic              swr_fire_i,
  output logic [LOCK_W-1:0] lock_q
);
  logic [LOCK_W-1:0] lock_d;
  logic              lock_en;

  always_comb begin
    lock_en = wr_i | swr_fire_i;
    lock_d  = lock_q;
    if (swr_fire_i) lock_d = '1;
    else if (wr_i)  lock_d = lock_q & wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '1;
    else if (lock_en) lock_q <= lock_d;
  end

  // lock bits may only rise through a software reset
  assert_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !swr_fire_i |=> ((lock_q & ~$past(lock_q)) == '0));

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !swr_fire_i) |=> (lock_q == ($past(lock_q) & $past(wdata_i))));
endmodule

// File: rtl/reg_guard_ctrl.sv
module reg_guard_ctrl
  import reg_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_q,
  output logic              swr_fire_o,
  output logic              sw_reset_o
);
  ctrl_t ctrl_d;
  logic  pulse_d;

  always_comb begin
    swr_fire_o = wr_i & wdata_i[CB_SWR];
    pulse_d    = swr_fire_o;
    ctrl_d     = ctrl_q;
    if (swr_fire_o)  ctrl_d = ctrl_t'(CTRL_W'(1) << CB_SWR);
    else if (wr_i)   ctrl_d = ctrl_t'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      sw_reset_o <= 1'b0;
    end else begin
      sw_reset_o <= pulse_d;
      if (wr_i) ctrl_q <= ctrl_d;
    end
  end

  assert_swrst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    swr_fire_o |=> (sw_reset_o && ctrl_q.swr && !ctrl_q.um && !ctrl_q.sup));

  assert_swr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/reg_guard.sv
module reg_guard
  import reg_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                priv,
  input  logic                time_invalid,
  input  logic                time_overflow,
  input  logic                cnt_enabled,
  output logic [NUM_REGS-1:0] wr_ok,
  output logic                bus_err,
  output logic                sw_reset,
  output logic [LOCK_W-1:0]   lock_state,
  output logic                upd_mode,
  output logic                sup_en,
  output logic                swr_flag
);
  logic [1:0]  rst_sync;
  logic        rst_int_n;
  logic        accept;
  logic        swr_fire;
  ctrl_t       ctrl_q;
  logic [LOCK_W-1:0] lock_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  reg_guard_access u_access (
    .wr_en_i   (wr_en),
    .priv_i    (priv),
    .sup_en_i  (ctrl_q.sup),
    .accept_o  (accept),
    .bus_err_o (bus_err)
  );

  reg_guard_gate u_gate (
    .accept_i   (accept),
    .addr_i     (wr_addr),
    .lock_i     (lock_q),
    .um_i       (ctrl_q.um),
    .invalid_i  (time_invalid),
    .overflow_i (time_overflow),
    .cnt_en_i   (cnt_enabled),
    .wr_ok_o    (wr_ok)
  );

  reg_guard_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_i       (wr_ok[IDX_LOCK]),
    .wdata_i    (wr_data[LOCK_W-1:0]),
    .swr_fire_i (swr_fire),
    .lock_q     (lock_q)
  );

  reg_guard_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_i       (wr_ok[IDX_CTRL]),
    .wdata_i    (wr_data[CTRL_W-1:0]),
    .ctrl_q     (ctrl_q),
    .swr_fire_o (swr_fire),
    .sw_reset_o (sw_reset)
  );

  assign lock_state = lock_q;
  assign upd_mode   = ctrl_q.um;
  assign sup_en     = ctrl_q.sup;
  assign swr_flag   = ctrl_q.swr;

  assert_err_no_write_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_err |-> (wr_ok == '0));

  assert_err_no_change_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_err |=> ($stable(lock_q) && $stable(ctrl_q)));

  assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(wr_ok));

  assert_needs_strobe_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_ok != '0) |-> wr_en);

  assert_override_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && priv && wr_addr == ADDR_W'(IDX_STATUS) && ctrl_q.um && time_invalid)
      |-> wr_ok[IDX_STATUS]);
endmodule

// File: tb/test_reg_guard.sv
module test_reg_guard;
  import reg_guard_pkg::*;

  logic                clk;
  logic                rst_n;
  logic                wr_en;
  logic [ADDR_W-1:0]   wr_addr;
  logic [DATA_W-1:0]   wr_data;
  logic                priv;
  logic                time_invalid;
  logic                time_overflow;
  logic                cnt_enabled;
  logic [NUM_REGS-1:0] wr_ok;
  logic                bus_err;
  logic                sw_reset;
  logic [LOCK_W-1:0]   lock_state;
  logic                upd_mode;
  logic                sup_en;
  logic                swr_flag;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [NUM_REGS-1:0] ok;
    logic                err;
    string               tag;
  } exp_t;
  exp_t sb[$];

  reg_guard i_reg_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .priv(priv), .time_invalid(time_invalid),
    .time_overflow(time_overflow), .cnt_enabled(cnt_enabled),
    .wr_ok(wr_ok), .bus_err(bus_err), .sw_reset(sw_reset),
    .lock_state(lock_state), .upd_mode(upd_mode), .sup_en(sup_en),
    .swr_flag(swr_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare combinational results mid-cycle
  always @(negedge clk) begin
    if (wr_en) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R12 unexpected write: actual=%0h expected=none", wr_ok);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " wr_ok"}, 32'(wr_ok), 32'(e.ok));
        chk({e.tag, " bus_err"}, 32'(bus_err), 32'(e.err));
      end
    end
  end

  // driver: one write, expectation pushed to scoreboard
  task automatic wr(input int a, input logic [DATA_W-1:0] d, input logic p,
                    input logic [NUM_REGS-1:0] eok, input logic eerr, input string tag);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; priv = p;
    sb.push_back('{eok, eerr, tag});
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic por();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wr_en = 0; wr_addr = '0; wr_data = '0; priv = 0;
    time_invalid = 0; time_overflow = 0; cnt_enabled = 1;
    por();
    chk("R1 lock", 32'(lock_state), 32'hF);
    chk("R1 ctrl", 32'({upd_mode, sup_en, swr_flag}), 32'h0);
    chk("R1 sw_reset", 32'(sw_reset), 0);
    chk("R1 bus_err", 32'(bus_err), 0);

    wr(IDX_SECONDS, 4'h0, 1, 8'h01, 0, "R12 seconds");
    wr(IDX_ALARM,   4'h5, 0, 8'h00, 1, "R8 user write refused");
    chk("R8 lock unchanged", 32'(lock_state), 32'hF);
    chk("R8 ctrl unchanged", 32'({upd_mode, sup_en, swr_flag}), 32'h0);
    wr(IDX_CTRL,    4'b0010, 1, 8'h10, 0, "R8 enable supervisor access");
    chk("R8 sup set", 32'(sup_en), 1);
    wr(IDX_ALARM,   4'h0, 0, 8'h04, 0, "R8 user write allowed");

    wr(IDX_COMP,    4'h0, 1, 8'h08, 0, "R5 comp open");
    wr(IDX_LOCK,    4'b0111, 1, 8'h40, 0, "R2 clear comp lock");
    chk("R2 lock", 32'(lock_state), 32'h7);
    wr(IDX_COMP,    4'h0, 1, 8'h00, 0, "R5 R9 comp locked");
    wr(IDX_LOCK,    4'hF, 1, 8'h40, 0, "R2 try set");
    chk("R2 no set", 32'(lock_state), 32'h7);

    wr(IDX_STATUS,  4'h1, 1, 8'h20, 0, "R6 status open");
    wr(IDX_LOCK,    4'b0101, 1, 8'h40, 0, "R2 clear status lock");
    chk("R2 lock", 32'(lock_state), 32'h5);
    wr(IDX_STATUS,  4'h1, 1, 8'h00, 0, "R6 status locked");
    wr(IDX_CTRL,    4'b0110, 1, 8'h10, 0, "R7 update mode on");
    chk("R7 um", 32'(upd_mode), 1);
    wr(IDX_STATUS,  4'h1, 1, 8'h00, 0, "R7 no condition");
    time_invalid = 1;
    wr(IDX_STATUS,  4'h1, 1, 8'h20, 0, "R7 invalid");
    time_invalid = 0; time_overflow = 1;
    wr(IDX_STATUS,  4'h1, 1, 8'h20, 0, "R7 overflow");
    time_overflow = 0; cnt_enabled = 0;
    wr(IDX_STATUS,  4'h1, 1, 8'h20, 0, "R7 counter stopped");
    cnt_enabled = 1;

    wr(IDX_CTRL,    4'b0111, 1, 8'h10, 0, "R10 software reset");
    chk("R10 pulse", 32'(sw_reset), 1);
    chk("R10 lock", 32'(lock_state), 32'hF);
    chk("R10 ctrl", 32'({upd_mode, sup_en, swr_flag}), 32'h1);
    @(posedge clk); #1;
    chk("R10 pulse ends", 32'(sw_reset), 0);
    wr(IDX_SECONDS, 4'h0, 1, 8'h01, 0, "R11 other write");
    wr(IDX_IRQEN,   4'h3, 1, 8'h80, 0, "R12 irq enable");
    wr(IDX_PRESCAL, 4'h0, 1, 8'h02, 0, "R12 prescaler");
    chk("R11 swr kept", 32'(swr_flag), 1);

    wr(IDX_LOCK,    4'b1011, 1, 8'h40, 0, "R4 clear ctrl lock");
    wr(IDX_CTRL,    4'b0000, 1, 8'h00, 0, "R4 R9 ctrl locked");
    chk("R4 swr kept", 32'(swr_flag), 1);
    wr(IDX_CTRL,    4'b0001, 1, 8'h00, 0, "R4 no reset while locked");
    chk("R4 no pulse", 32'(sw_reset), 0);
    chk("R4 lock", 32'(lock_state), 32'hB);

    wr(IDX_LOCK,    4'b1010, 1, 8'h40, 0, "R3 clear self lock");
    wr(IDX_LOCK,    4'b0000, 1, 8'h00, 0, "R3 lock reg locked");
    chk("R3 lock kept", 32'(lock_state), 32'hA);

    por();
    chk("R1 lock after por", 32'(lock_state), 32'hF);
    chk("R11 swr after por", 32'(swr_flag), 0);
    wr(IDX_CTRL,    4'b0001, 1, 8'h10, 0, "R11 set swr");
    chk("R11 swr set", 32'(swr_flag), 1);
    wr(IDX_CTRL,    4'b0000, 1, 8'h10, 0, "R11 clear swr");
    chk("R11 swr cleared", 32'(swr_flag), 0);

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule